// File: doc/BRIEF.md
# Sine-Cosine Stack Sequencer

This block runs the control side of a floating-point instruction that takes the top of an eight-deep register stack of 80-bit extended-precision values and leaves two results there: the sine takes the operand's old slot and the cosine is pushed above it. The block holds the stack and its per-entry valid tags, the 3-bit stack pointer, two condition bits (C1, C2) and five sticky exception flags. It sorts the operand into a class, tests whether the operand is in range, settles every special value itself, and orders the stack writes.

For finite, in-range operands it hands the operand to an external arithmetic unit over a request/acknowledge handshake and takes back the two magnitudes with their inexact, underflow and rounded-up indications. Zeros, infinities, NaNs and unsupported encodings never reach that unit. An operand whose magnitude is 2^63 or more is rejected without a trace other than C2. A load port pushes values onto the stack, and a read port shows any entry relative to the current top.

Top module: `trig_stack_seq`

## Requirements
- R1: After reset the stack pointer is 0, every entry is empty (read data 0, valid 0), C1 and C2 are 0 and all five exception flags are 0. The flag vector bit order is bit 0 invalid, bit 1 denormal, bit 2 stack fault, bit 3 underflow, bit 4 precision.
- R2: A finite normal operand (explicit integer bit set) with biased exponent at least 16446 (bias 16383 plus 63) and below 32767 sets C2 to 1 and leaves the stack, the pointer, C1 and all flags unchanged.
- R3: A normal or denormal operand below that limit is sent to the arithmetic unit; after the acknowledge the sine sits in ST(1), the cosine in ST(0), the pointer has moved down by one (modulo 8), C2 is 0, C1 equals the unit's rounded-up bit, and the unit's precision and underflow bits are ORed into flags 4 and 3.
- R4: A zero operand needs no arithmetic unit: the sine keeps the operand's sign and zero value, the cosine is +1 (exponent 16383, significand 0x8000000000000000), and no flag is raised.
- R5: An infinity, a signaling NaN (quiet bit 62 clear) or an unsupported encoding (exponent not zero and integer bit 63 clear) sets the invalid flag. With the invalid mask input high both results are pushed: the input NaN with bit 62 set for a signaling NaN, otherwise the indefinite value (sign 1, exponent 32767, significand 0xC000000000000000). With the mask low the stack and pointer are unchanged.
- R6: A quiet NaN operand is written unchanged into both result positions and raises no flag.
- R7: A denormal operand (exponent 0, significand nonzero) sets the denormal flag and takes the arithmetic path of R3.
- R8: If ST(0) is empty the stack-fault flag is set, C1 is 0, no request is made and the stack is unchanged; this check comes before every other one.
- R9: If ST(0) is valid but the entry one below the pointer is valid, the stack-fault flag is set, C1 is 1 and the stack is unchanged; this check comes before the range check.
- R10: The load port pushes its data onto the stack when the block is idle and no start is given in the same cycle; a load while the block is busy is ignored.
- R11: Exception flags are sticky: once set they stay set until reset.
- R12: Each instruction ends with a single-cycle done pulse and the request output is only high while the block is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin one instruction on the current ST(0) |
| inv_mask_i | input | 1 | Invalid exception masked: write default results |
| ld_valid_i | input | 1 | Push ld_data_i onto the stack |
| ld_data_i | input | 80 | Value to push |
| rd_rel_i | input | 3 | Read index relative to the stack pointer |
| rd_data_o | output | 80 | Entry ST(rd_rel_i) |
| rd_valid_o | output | 1 | Tag of entry ST(rd_rel_i) |
| top_o | output | 3 | Stack pointer |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | One-cycle end-of-instruction pulse |
| c1_o | output | 1 | Condition bit C1 |
| c2_o | output | 1 | Condition bit C2 (out of range) |
| exc_o | output | 5 | Sticky exception flags |
| arith_req_o | output | 1 | Request to the arithmetic unit |
| arith_op_o | output | 80 | Operand for the arithmetic unit |
| arith_ack_i | input | 1 | Results valid |
| arith_sin_i | input | 80 | Sine result |
| arith_cos_i | input | 80 | Cosine result |
| arith_pe_i | input | 1 | Result inexact |
| arith_ue_i | input | 1 | Result underflowed |
| arith_rup_i | input | 1 | Result rounded up |

## Verification
A wrong classification or a wrong state step shows at the ports within the same instruction: the done pulse arrives with the wrong C2, the pointer has moved when it should not (or not moved), or the two entries read back at ST(0) and ST(1) are swapped, stale or not the expected special value. A corrupted tag shows one instruction later as a false or missing stack fault, and a lost sticky flag shows at the next done pulse. The bench therefore reads the pointer, both result entries, C1, C2 and the flags at every done pulse, sweeping the exponent across the range limit for both signs.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;

    localparam int unsigned FP_W     = 80;
    localparam int unsigned EXP_W    = 15;
    localparam int unsigned SIG_W    = 64;
    localparam int unsigned EXP_BIAS = 16383;
    localparam int unsigned EXC_W    = 5;

    localparam logic [EXP_W-1:0] EXP_ALL_ONES = '1;

    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] exp;
        logic [SIG_W-1:0] sig;
    } fp80_t;

    typedef enum logic [2:0] {
        K_ZERO,
        K_NORMAL,
        K_DENORM,
        K_INF,
        K_QNAN,
        K_SNAN,
        K_UNSUP
    } fp_kind_e;

    typedef struct packed {
        fp_kind_e kind;
        logic     oor;
    } fp_class_t;

    // Flag vector, bit 0 first: invalid, denormal, stack fault, underflow, precision.
    typedef struct packed {
        logic pe;
        logic ue;
        logic sf;
        logic de;
        logic ie;
    } exc_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVAL,
        ST_WAIT,
        ST_WSIN,
        ST_WCOS
    } seq_state_e;

    localparam fp80_t FP_POS_ONE = '{sign: 1'b0, exp: 15'h3FFF,
                                     sig: 64'h8000_0000_0000_0000};
    localparam fp80_t FP_INDEF   = '{sign: 1'b1, exp: 15'h7FFF,
                                     sig: 64'hC000_0000_0000_0000};

    function automatic fp80_t make_quiet(fp80_t x);
        fp80_t q;
        q = x;
        q.sig[SIG_W-2] = 1'b1;
        return q;
    endfunction

endpackage

// File: rtl/fp80_classify.sv
module fp80_classify
    import trig_seq_pkg::*;
#(
    parameter int unsigned RANGE_LOG2 = 63
) (
    input  fp80_t     op_i,
    output fp_class_t cls_o
);
    localparam logic [EXP_W-1:0] EXP_LIMIT = EXP_W'(EXP_BIAS + RANGE_LOG2);

    logic sig_zero;
    logic frac_zero;

    assign sig_zero  = (op_i.sig == '0);
    assign frac_zero = (op_i.sig[SIG_W-2:0] == '0);

    always_comb begin
        cls_o.kind = K_NORMAL;
        cls_o.oor  = 1'b0;
        if (op_i.exp == EXP_ALL_ONES) begin
            if (!op_i.sig[SIG_W-1])      cls_o.kind = K_UNSUP;
            else if (frac_zero)          cls_o.kind = K_INF;
            else if (op_i.sig[SIG_W-2])  cls_o.kind = K_QNAN;
            else                         cls_o.kind = K_SNAN;
        end else if (op_i.exp == '0) begin
            cls_o.kind = sig_zero ? K_ZERO : K_DENORM;
        end else if (!op_i.sig[SIG_W-1]) begin
            cls_o.kind = K_UNSUP;
        end else begin
            cls_o.kind = K_NORMAL;
            cls_o.oor  = (op_i.exp >= EXP_LIMIT);
        end
    end
endmodule

// File: rtl/fp_stack_regs.sv
module fp_stack_regs
    import trig_seq_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_i,
    input  logic             wr0_i,
    input  fp80_t            wdata_i,
    input  logic [PTR_W-1:0] rd_rel_i,
    output logic [PTR_W-1:0] top_o,
    output fp80_t            st0_o,
    output logic             st0_vld_o,
    output logic             below_vld_o,
    output fp80_t            rd_data_o,
    output logic             rd_vld_o
);
    localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);

    fp80_t            mem  [DEPTH];
    logic [DEPTH-1:0] tags;
    logic [PTR_W-1:0] top_q;
    logic [PTR_W-1:0] top_dn;
    logic [PTR_W-1:0] wr_idx;
    logic             wr_any;

    assign top_dn = top_q - PTR_ONE;
    assign wr_idx = push_i ? top_dn : top_q;
    assign wr_any = push_i | wr0_i;

    always_ff @(posedge clk) begin
        if (rst)         top_q <= '0;
        else if (push_i) top_q <= top_dn;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[g]  <= '0;
                tags[g] <= 1'b0;
            end else if (wr_any && (wr_idx == PTR_W'(g))) begin
                mem[g]  <= wdata_i;
                tags[g] <= 1'b1;
            end
        end
    end

    assign top_o       = top_q;
    assign st0_o       = mem[top_q];
    assign st0_vld_o   = tags[top_q];
    assign below_vld_o = tags[top_dn];
    assign rd_data_o   = mem[top_q + rd_rel_i];
    assign rd_vld_o    = tags[top_q + rd_rel_i];
endmodule

// File: rtl/sincos_ctrl.sv
module sincos_ctrl
    import trig_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start_i,
    input  logic      inv_mask_i,
    input  fp80_t     st0_i,
    input  logic      st0_vld_i,
    input  logic      below_vld_i,
    output fp80_t     op_o,
    input  fp_class_t cls_i,
    output logic      arith_req_o,
    input  logic      arith_ack_i,
    input  fp80_t     arith_sin_i,
    input  fp80_t     arith_cos_i,
    input  logic      arith_pe_i,
    input  logic      arith_ue_i,
    input  logic      arith_rup_i,
    output logic      push_o,
    output logic      wr0_o,
    output fp80_t     wdata_o,
    output logic      busy_o,
    output logic      done_o,
    output logic      c1_o,
    output logic      c2_o,
    output exc_t      exc_o
);
    seq_state_e state_q;
    fp80_t      op_q;
    fp80_t      sin_q;
    fp80_t      cos_q;
    logic       vld_q;
    logic       below_q;
    logic       mask_q;
    logic       done_q;
    logic       c1_q;
    logic       c2_q;
    exc_t       exc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_q    <= '0;
            sin_q   <= '0;
            cos_q   <= '0;
            vld_q   <= 1'b0;
            below_q <= 1'b0;
            mask_q  <= 1'b0;
            done_q  <= 1'b0;
            c1_q    <= 1'b0;
            c2_q    <= 1'b0;
            exc_q   <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        op_q    <= st0_i;
                        vld_q   <= st0_vld_i;
                        below_q <= below_vld_i;
                        mask_q  <= inv_mask_i;
                        state_q <= ST_EVAL;
                    end
                end
                ST_EVAL: begin
                    c2_q <= 1'b0;
                    c1_q <= 1'b0;
                    if (!vld_q) begin
                        exc_q.sf <= 1'b1;
                        done_q   <= 1'b1;
                        state_q  <= ST_IDLE;
                    end else if (below_q) begin
                        exc_q.sf <= 1'b1;
                        c1_q     <= 1'b1;
                        done_q   <= 1'b1;
                        state_q  <= ST_IDLE;
                    end else if (cls_i.oor) begin
                        c2_q    <= 1'b1;
                        c1_q    <= c1_q;
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        unique case (cls_i.kind)
                            K_ZERO: begin
                                sin_q   <= op_q;
                                cos_q   <= FP_POS_ONE;
                                state_q <= ST_WSIN;
                            end
                            K_QNAN: begin
                                sin_q   <= op_q;
                                cos_q   <= op_q;
                                state_q <= ST_WSIN;
                            end
                            K_SNAN: begin
                                exc_q.ie <= 1'b1;
                                sin_q    <= make_quiet(op_q);
                                cos_q    <= make_quiet(op_q);
                                done_q   <= !mask_q;
                                state_q  <= mask_q ? ST_WSIN : ST_IDLE;
                            end
                            K_INF, K_UNSUP: begin
                                exc_q.ie <= 1'b1;
                                sin_q    <= FP_INDEF;
                                cos_q    <= FP_INDEF;
                                done_q   <= !mask_q;
                                state_q  <= mask_q ? ST_WSIN : ST_IDLE;
                            end
                            K_DENORM: begin
                                exc_q.de <= 1'b1;
                                state_q  <= ST_WAIT;
                            end
                            default: begin
                                state_q <= ST_WAIT;
                            end
                        endcase
                    end
                end
                ST_WAIT: begin
                    if (arith_ack_i) begin
                        sin_q    <= arith_sin_i;
                        cos_q    <= arith_cos_i;
                        c1_q     <= arith_rup_i;
                        exc_q.pe <= exc_q.pe | arith_pe_i;
                        exc_q.ue <= exc_q.ue | arith_ue_i;
                        state_q  <= ST_WSIN;
                    end
                end
                ST_WSIN: begin
                    state_q <= ST_WCOS;
                end
                ST_WCOS: begin
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign op_o        = op_q;
    assign arith_req_o = (state_q == ST_WAIT);
    assign wr0_o       = (state_q == ST_WSIN);
    assign push_o      = (state_q == ST_WCOS);
    assign wdata_o     = (state_q == ST_WCOS) ? cos_q : sin_q;
    assign busy_o      = (state_q != ST_IDLE);
    assign done_o      = done_q;
    assign c1_o        = c1_q;
    assign c2_o        = c2_q;
    assign exc_o       = exc_q;
endmodule

// File: rtl/trig_stack_seq.sv
module trig_stack_seq
    import trig_seq_pkg::*;
#(
    parameter int unsigned DEPTH      = 8,
    parameter int unsigned RANGE_LOG2 = 63,
    localparam int unsigned PTR_W     = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic               inv_mask_i,
    input  logic               ld_valid_i,
    input  logic [FP_W-1:0]    ld_data_i,
    input  logic [PTR_W-1:0]   rd_rel_i,
    output logic [FP_W-1:0]    rd_data_o,
    output logic               rd_valid_o,
    output logic [PTR_W-1:0]   top_o,
    output logic               busy_o,
    output logic               done_o,
    output logic               c1_o,
    output logic               c2_o,
    output logic [EXC_W-1:0]   exc_o,
    output logic               arith_req_o,
    output logic [FP_W-1:0]    arith_op_o,
    input  logic               arith_ack_i,
    input  logic [FP_W-1:0]    arith_sin_i,
    input  logic [FP_W-1:0]    arith_cos_i,
    input  logic               arith_pe_i,
    input  logic               arith_ue_i,
    input  logic               arith_rup_i
);
    fp80_t     st0;
    logic      st0_vld;
    logic      below_vld;
    fp80_t     op;
    fp_class_t cls;
    logic      ctl_push;
    logic      ctl_wr0;
    fp80_t     ctl_wdata;
    logic      ld_take;
    logic      push;
    logic      wr0;
    fp80_t     wdata;
    fp80_t     rd_data;
    exc_t      exc;

    // Loads only in idle and never in the cycle of a start (R10).
    assign ld_take = ld_valid_i && !busy_o && !start_i;
    assign push    = busy_o ? ctl_push : ld_take;
    assign wr0     = busy_o && ctl_wr0;
    assign wdata   = busy_o ? ctl_wdata : fp80_t'(ld_data_i);

    fp_stack_regs #(.DEPTH(DEPTH)) u_stack (
        .clk        (clk),
        .rst        (rst),
        .push_i     (push),
        .wr0_i      (wr0),
        .wdata_i    (wdata),
        .rd_rel_i   (rd_rel_i),
        .top_o      (top_o),
        .st0_o      (st0),
        .st0_vld_o  (st0_vld),
        .below_vld_o(below_vld),
        .rd_data_o  (rd_data),
        .rd_vld_o   (rd_valid_o)
    );

    fp80_classify #(.RANGE_LOG2(RANGE_LOG2)) u_class (
        .op_i (op),
        .cls_o(cls)
    );

    sincos_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .inv_mask_i (inv_mask_i),
        .st0_i      (st0),
        .st0_vld_i  (st0_vld),
        .below_vld_i(below_vld),
        .op_o       (op),
        .cls_i      (cls),
        .arith_req_o(arith_req_o),
        .arith_ack_i(arith_ack_i),
        .arith_sin_i(fp80_t'(arith_sin_i)),
        .arith_cos_i(fp80_t'(arith_cos_i)),
        .arith_pe_i (arith_pe_i),
        .arith_ue_i (arith_ue_i),
        .arith_rup_i(arith_rup_i),
        .push_o     (ctl_push),
        .wr0_o      (ctl_wr0),
        .wdata_o    (ctl_wdata),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .c1_o       (c1_o),
        .c2_o       (c2_o),
        .exc_o      (exc)
    );

    assign rd_data_o  = rd_data;
    assign exc_o      = exc;
    assign arith_op_o = op;
endmodule

// File: rtl/trig_stack_seq_chk.sv
module trig_stack_seq_chk #(
    parameter int unsigned PTR_W = 3,
    parameter int unsigned EXC_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             busy_o,
    input logic             done_o,
    input logic             c2_o,
    input logic [PTR_W-1:0] top_o,
    input logic [EXC_W-1:0] exc_o,
    input logic             arith_req_o
);
    // R12: the arithmetic request is only raised inside an instruction
    a_r12_req_in_busy: assert property (@(posedge clk) disable iff (rst)
        arith_req_o |-> busy_o);

    // R12: done lasts one cycle
    a_r12_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R2: an out-of-range completion leaves pointer and flags as they were
    a_r2_oor_silent: assert property (@(posedge clk) disable iff (rst)
        (done_o && c2_o) |-> ($stable(top_o) && $stable(exc_o)));

    // R11: flags never clear outside reset
    a_r11_sticky: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((exc_o & $past(exc_o)) == $past(exc_o)));

    // R3: the pointer only ever steps down by one
    a_r3_top_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((top_o == $past(top_o)) ||
                  (top_o == PTR_W'($past(top_o) - PTR_W'(1)))));
endmodule

bind trig_stack_seq trig_stack_seq_chk #(.PTR_W(PTR_W), .EXC_W(trig_seq_pkg::EXC_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .c2_o       (c2_o),
    .top_o      (top_o),
    .exc_o      (exc_o),
    .arith_req_o(arith_req_o)
);

// File: tb/trig_stack_seq_tb_top.sv
module trig_stack_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        inv_mask_i = 1'b0;
    logic        ld_valid_i = 1'b0;
    logic [79:0] ld_data_i = '0;
    logic [2:0]  rd_rel_i = '0;
    logic [79:0] rd_data_o;
    logic        rd_valid_o;
    logic [2:0]  top_o;
    logic        busy_o, done_o, c1_o, c2_o;
    logic [4:0]  exc_o;
    logic        arith_req_o;
    logic [79:0] arith_op_o;
    logic        arith_ack_i = 1'b0;
    logic [79:0] arith_sin_i = '0;
    logic [79:0] arith_cos_i = '0;
    logic        arith_pe_i = 1'b0, arith_ue_i = 1'b0, arith_rup_i = 1'b0;

    int errors = 0;
    int checks = 0;

    localparam logic [79:0] ONE_P  = {1'b0, 15'h3FFF, 64'h8000_0000_0000_0000};
    localparam logic [79:0] INDEF  = {1'b1, 15'h7FFF, 64'hC000_0000_0000_0000};

    trig_stack_seq dut_i (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // Stand-in arithmetic unit: answers two cycles after a request.
    function automatic logic [79:0] sin_m(input logic [79:0] x);
        return {x[79], 15'h3FFE, x[63:0] ^ 64'h5A5A_A5A5_0F0F_F0F0};
    endfunction
    function automatic logic [79:0] cos_m(input logic [79:0] x);
        return {1'b0, 15'h3FFD, ~x[63:0]};
    endfunction

    initial begin
        int cnt;
        cnt = 0;
        forever begin
            @(negedge clk);
            if (arith_req_o && !arith_ack_i) begin
                cnt++;
                if (cnt == 2) begin
                    arith_ack_i = 1'b1;
                    arith_sin_i = sin_m(arith_op_o);
                    arith_cos_i = cos_m(arith_op_o);
                    arith_pe_i  = arith_op_o[0];
                    arith_ue_i  = arith_op_o[1];
                    arith_rup_i = arith_op_o[2];
                end
            end else begin
                arith_ack_i = 1'b0;
                cnt = 0;
            end
        end
    end

    task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic load(input logic [79:0] v);
        @(negedge clk);
        ld_valid_i = 1'b1;
        ld_data_i  = v;
        @(negedge clk);
        ld_valid_i = 1'b0;
    endtask

    task automatic read_rel(input int r, output logic [79:0] d, output logic v);
        rd_rel_i = 3'(r);
        #1;
        d = rd_data_o;
        v = rd_valid_o;
    endtask

    task automatic run_op(input logic mask, input logic ld_during);
        @(negedge clk);
        start_i    = 1'b1;
        inv_mask_i = mask;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 40; i++) begin
            if (done_o) break;
            if (ld_during && busy_o) begin
                ld_valid_i = 1'b1;
                ld_data_i  = 80'h1234;
            end else begin
                ld_valid_i = 1'b0;
            end
            @(negedge clk);
        end
        ld_valid_i = 1'b0;
        checks++;
        if (!done_o) begin
            errors++;
            $display("FAIL R12: actual=done0 expected=done1");
        end
    endtask

    task automatic expect_state(input string req, input logic [79:0] e0, input logic [79:0] e1,
                                input int etop, input logic ec1, input logic ec2,
                                input logic [4:0] eexc);
        logic [79:0] d;
        logic v;
        read_rel(0, d, v);
        check({req, " ST0"}, d, e0);
        read_rel(1, d, v);
        check({req, " ST1"}, d, e1);
        check({req, " TOP"}, 80'(top_o), 80'(etop));
        check({req, " C1"}, 80'(c1_o), 80'(ec1));
        check({req, " C2"}, 80'(c2_o), 80'(ec2));
        check({req, " EXC"}, 80'(exc_o), 80'(eexc));
    endtask

    // Single-instruction case after a fresh reset with one loaded operand.
    task automatic one_case(input string req, input logic [79:0] op, input logic mask,
                            input logic [79:0] e0, input logic [79:0] e1, input int etop,
                            input logic ec1, input logic ec2, input logic [4:0] eexc);
        do_reset();
        load(op);
        run_op(mask, 1'b0);
        @(negedge clk);
        expect_state(req, e0, e1, etop, ec1, ec2, eexc);
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [79:0] d;
        logic v;
        logic [79:0] op;

        // R1 reset state
        do_reset();
        @(negedge clk);
        read_rel(0, d, v);
        check("R1 ST0 data", d, 80'h0);
        check("R1 ST0 tag", 80'(v), 80'h0);
        check("R1 TOP", 80'(top_o), 80'h0);
        check("R1 flags", 80'({c1_o, c2_o, exc_o}), 80'h0);

        // R2/R3 exponent sweep across the range limit for both signs
        for (int s = 0; s < 2; s++) begin
            for (int e = 16438; e <= 16452; e++) begin
                op = {1'(s), 15'(e), 64'h8000_1234_5678_9AB0};
                if (e >= 16383 + 63)
                    one_case("R2 out of range", op, 1'b0, op, 80'h0, 7, 1'b0, 1'b1, 5'b00000);
                else
                    one_case("R3 in range", op, 1'b0, cos_m(op), sin_m(op), 6, 1'b0, 1'b0, 5'b00000);
            end
        end
        op = {1'b0, 15'h7FFE, 64'hFFFF_FFFF_FFFF_FFF0};
        one_case("R2 largest finite", op, 1'b0, op, 80'h0, 7, 1'b0, 1'b1, 5'b00000);

        // R3 unit flags: precision + rounded up, then underflow
        op = {1'b1, 15'h3FFF, 64'hC000_0000_0000_0005};
        one_case("R3 pe rup", op, 1'b0, cos_m(op), sin_m(op), 6, 1'b1, 1'b0, 5'b10000);
        op = {1'b0, 15'h0001, 64'hC000_0000_0000_0002};
        one_case("R3 ue", op, 1'b0, cos_m(op), sin_m(op), 6, 1'b0, 1'b0, 5'b01000);

        // R4 zeros
        op = {1'b0, 15'h0, 64'h0};
        one_case("R4 +0", op, 1'b0, ONE_P, op, 6, 1'b0, 1'b0, 5'b00000);
        op = {1'b1, 15'h0, 64'h0};
        one_case("R4 -0", op, 1'b0, ONE_P, op, 6, 1'b0, 1'b0, 5'b00000);

        // R5 invalid operands
        op = {1'b0, 15'h7FFF, 64'h8000_0000_0000_0000};
        one_case("R5 +inf masked", op, 1'b1, INDEF, INDEF, 6, 1'b0, 1'b0, 5'b00001);
        op = {1'b1, 15'h7FFF, 64'h8000_0000_0000_0000};
        one_case("R5 -inf masked", op, 1'b1, INDEF, INDEF, 6, 1'b0, 1'b0, 5'b00001);
        one_case("R5 -inf unmasked", op, 1'b0, op, 80'h0, 7, 1'b0, 1'b0, 5'b00001);
        op = {1'b0, 15'h7FFF, 64'h8000_0000_0000_0001};
        one_case("R5 snan masked", op, 1'b1, {1'b0, 15'h7FFF, 64'hC000_0000_0000_0001},
                 {1'b0, 15'h7FFF, 64'hC000_0000_0000_0001}, 6, 1'b0, 1'b0, 5'b00001);
        one_case("R5 snan unmasked", op, 1'b0, op, 80'h0, 7, 1'b0, 1'b0, 5'b00001);
        op = {1'b0, 15'h4000, 64'h4000_0000_0000_0000};
        one_case("R5 unnormal masked", op, 1'b1, INDEF, INDEF, 6, 1'b0, 1'b0, 5'b00001);

        // R6 quiet NaN
        op = {1'b1, 15'h7FFF, 64'hE000_0000_0000_0042};
        one_case("R6 qnan", op, 1'b0, op, op, 6, 1'b0, 1'b0, 5'b00000);

        // R7 denormal
        op = {1'b0, 15'h0, 64'h0000_0000_0000_0005};
        one_case("R7 denormal", op, 1'b0, cos_m(op), sin_m(op), 6, 1'b1, 1'b0, 5'b10010);

        // R8 underflow: empty stack
        do_reset();
        run_op(1'b0, 1'b0);
        @(negedge clk);
        expect_state("R8 underflow", 80'h0, 80'h0, 0, 1'b0, 1'b0, 5'b00100);

        // R11 sticky: stack-fault flag survives a clean instruction
        op = {1'b0, 15'h3FFF, 64'h8000_0000_0000_0000};
        load(op);
        run_op(1'b0, 1'b0);
        @(negedge clk);
        expect_state("R11 sticky", cos_m(op), sin_m(op), 6, 1'b0, 1'b0, 5'b00100);

        // R9 overflow: full stack, out-of-range top still reports overflow
        do_reset();
        for (int k = 0; k < 7; k++) load({1'b0, 15'h3FFF, 64'h8000_0000_0000_0000 | 64'(k << 8)});
        op = {1'b0, 15'h7000, 64'h8000_0000_0000_0000};
        load(op);
        run_op(1'b0, 1'b0);
        @(negedge clk);
        expect_state("R9 overflow", op, {1'b0, 15'h3FFF, 64'h8000_0000_0000_0600},
                     0, 1'b1, 1'b0, 5'b00100);

        // R10 load during a busy instruction is ignored
        do_reset();
        op = {1'b0, 15'h3FFE, 64'h9000_0000_0000_0000};
        load(op);
        check("R10 load pushes", 80'(top_o), 80'h7);
        run_op(1'b0, 1'b1);
        @(negedge clk);
        expect_state("R10 busy load", cos_m(op), sin_m(op), 6, 1'b0, 1'b0, 5'b00000);
        read_rel(2, d, v);
        check("R10 below untouched", 80'(v), 80'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule